// File: doc/BRIEF.md
# Fault-Injectable AES-128 Encryption Core

This block is an iterative AES-128 encryptor meant to sit inside a counter-mode random bit generator. Each encryption takes one 128-bit data block and one 128-bit key. The core spends one cycle capturing its operands and one cycle on the initial key whitening. It then runs ten rounds at one per clock, expanding each round key on the fly. The last round leaves out MixColumns.

The core also carries a single-bit-flip fault hook for robustness studies. A free-running 32-bit cycle counter arms the hook. When the counter matches a programmed trigger value, a one-hot mask is XORed into the next value of one chosen register: the captured plaintext, the captured key or the round-key register. The bench picks the trigger, the target and the bit index. While the hook is disabled, the datapath and its timing are exactly those of a plain encryptor.

Top module: `aes_fi_core`

## Requirements
- R1: With fi_en_i low, the value on ct_o when done_o is high equals the AES-128 encryption of pt_i under key_i, both sampled on the clock edge that accepted start_i. Bytes are taken most significant first.
- R2: done_o is high for exactly one cycle, and it rises on the 11th rising edge after the edge that accepted start_i. After that, ct_o holds its value until another start is accepted. After reset, done_o, ct_o and fi_fired_o are zero.
- R3: A start_i that arrives while an encryption is in progress is ignored. The running result is unchanged and no extra done_o pulse is produced.
- R4: A 32-bit counter resets to 0 and increments on every clock edge. A flip fires on an edge when fi_en_i is high, no flip has fired since arming, and the counter value before that edge equals fi_trig_i.
- R5: Target code 0 selects the plaintext register. The flip inverts bit fi_bit_i of the value written, where bit 0 is the LSB of the last byte and bit 127 is the MSB of the first byte. If the flip fires on the accepting edge, the result is AES(pt_i XOR mask, key_i).
- R6: Target code 1 selects the key register. If the flip fires on the accepting edge, the result is AES(pt_i, key_i XOR mask).
- R7: Target code 2 selects the round-key register. A flip that fires during the rounds makes ct_o differ from the fault-free result.
- R8: Target code 3 flips no register. The firing is still recorded in fi_fired_o, and ct_o equals the fault-free result.
- R9: At most one flip fires per arming. fi_fired_o rises on the edge where the flip fires and stays high while fi_en_i stays high. It clears on the first edge that samples fi_en_i low. Arming means fi_en_i goes high after being low.
- R10: With fi_en_i low, a counter match has no effect and fi_fired_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| pt_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| fi_en_i | input | 1 | Fault hook enable; a low-to-high change arms it |
| fi_tgt_i | input | 2 | Target: 0 plaintext, 1 key, 2 round key, 3 none |
| fi_bit_i | input | 7 | Index of the bit to flip |
| fi_trig_i | input | 32 | Counter value at which the flip fires |
| ct_o | output | 128 | Ciphertext |
| done_o | output | 1 | One-cycle completion pulse |
| fi_fired_o | output | 1 | Sticky flag: the flip fired since arming |

## Verification
The assertions check the following on every cycle: the counter steps by one, done_o is a single-cycle pulse at the end of a busy period, a start during a run does not restart the step sequence, the fired flag is sticky and fires at most once, and at most one flip mask is active and only while the hook is enabled. The correctness of the ciphertext can only be shown by the bench's scenarios. These include known-answer and random vectors against a bench model, exact expected results for plaintext and key flips, divergence after a round-key flip, and unchanged results with the hook disabled or aimed at no register.

// File: rtl/aes_fi_pkg.sv
package aes_fi_pkg;
  localparam int BLK_W     = 128;
  localparam int BIT_IDX_W = $clog2(BLK_W);
  localparam int NR        = 10;
  localparam int STEP_W    = 4;

  typedef enum logic [1:0] {
    TGT_PT   = 2'd0,
    TGT_KEY  = 2'd1,
    TGT_RK   = 2'd2,
    TGT_NONE = 2'd3
  } fi_tgt_e;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // x^254 is the field inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (i != 0) r = gf_mul(r, x);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input logic [STEP_W-1:0] r);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 1; i < NR; i++)
      if (STEP_W'(i) < r) c = xtime(c);
    return c;
  endfunction
endpackage

// File: rtl/aes_fi_round.sv
module aes_fi_round
  import aes_fi_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  logic [BLK_W-1:0] shr;
  logic [BLK_W-1:0] mix;

  // substitution and row shift merged: byte (row,col) takes byte (row,col+row)
  for (genvar i = 0; i < 16; i++) begin : g_byte
    localparam int ROW = i % 4;
    localparam int COL = i / 4;
    localparam int SRC = ROW + 4 * ((COL + ROW) % 4);
    assign shr[BLK_W-1-8*i -: 8] = sbox(state_i[BLK_W-1-8*SRC -: 8]);
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = shr[BLK_W-1-32*c    -: 8];
    assign a1 = shr[BLK_W-1-32*c-8  -: 8];
    assign a2 = shr[BLK_W-1-32*c-16 -: 8];
    assign a3 = shr[BLK_W-1-32*c-24 -: 8];
    assign mix[BLK_W-1-32*c -: 32] = {
      xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
      a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
      a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
      xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)
    };
  end

  assign state_o = (last_i ? shr : mix) ^ rkey_i;
endmodule

// File: rtl/aes_fi_key_step.sv
module aes_fi_key_step
  import aes_fi_pkg::*;
(
  input  logic [BLK_W-1:0]  rk_i,
  input  logic [STEP_W-1:0] rnd_i,
  output logic [BLK_W-1:0]  rk_o
);
  logic [31:0] w0, w1, w2, w3, tmp, n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = rk_i;
  // rotate, substitute, add round constant
  assign tmp = {sbox(w3[23:16]) ^ rcon(rnd_i), sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])};
  assign n0 = w0 ^ tmp;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign rk_o = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_fi_fault_ctrl.sv
module aes_fi_fault_ctrl
  import aes_fi_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           tgt_i,
  input  logic [BIT_IDX_W-1:0] bit_i,
  input  logic [CNT_W-1:0]     trig_i,
  output logic                 fire_o,
  output logic                 fired_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [BLK_W-1:0]     pt_mask_o,
  output logic [BLK_W-1:0]     key_mask_o,
  output logic [BLK_W-1:0]     rk_mask_o
);
  localparam int NUM_TGT = 3;

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [BLK_W-1:0] onehot;
  logic [NUM_TGT-1:0][BLK_W-1:0] masks;

  assign fire_o = en_i && !fired_q && (cnt_q == trig_i);
  assign onehot = {{(BLK_W-1){1'b0}}, 1'b1} << bit_i;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    localparam logic [1:0] CODE = 2'(t);
    assign masks[t] = (fire_o && tgt_i == CODE) ? onehot : '0;
  end

  assign pt_mask_o  = masks[TGT_PT];
  assign key_mask_o = masks[TGT_KEY];
  assign rk_mask_o  = masks[TGT_RK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (!en_i)       fired_q <= 1'b0;
      else if (fire_o) fired_q <= 1'b1;
    end
  end

  assign fired_o = fired_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/aes_fi_core.sv
module aes_fi_core
  import aes_fi_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [BLK_W-1:0]     pt_i,
  input  logic [BLK_W-1:0]     key_i,
  input  logic                 fi_en_i,
  input  logic [1:0]           fi_tgt_i,
  input  logic [BIT_IDX_W-1:0] fi_bit_i,
  input  logic [CNT_W-1:0]     fi_trig_i,
  output logic [BLK_W-1:0]     ct_o,
  output logic                 done_o,
  output logic                 fi_fired_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NR);

  logic [BLK_W-1:0]  pt_q, key_q, state_q, rk_q;
  logic [BLK_W-1:0]  pt_d, key_d, state_d, rk_d;
  logic [BLK_W-1:0]  rk_next, round_out;
  logic [BLK_W-1:0]  fi_pt_mask, fi_key_mask, fi_rk_mask;
  logic [CNT_W-1:0]  fi_cnt;
  logic              fi_fire;
  logic              busy_q, done_q, accept, whiten;
  logic [STEP_W-1:0] step_q;

  assign accept = start_i && !busy_q;
  assign whiten = busy_q && (step_q == '0);

  aes_fi_fault_ctrl #(.CNT_W(CNT_W)) u_fault (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (fi_en_i),
    .tgt_i      (fi_tgt_i),
    .bit_i      (fi_bit_i),
    .trig_i     (fi_trig_i),
    .fire_o     (fi_fire),
    .fired_o    (fi_fired_o),
    .cnt_o      (fi_cnt),
    .pt_mask_o  (fi_pt_mask),
    .key_mask_o (fi_key_mask),
    .rk_mask_o  (fi_rk_mask)
  );

  aes_fi_key_step u_key (
    .rk_i  (rk_q),
    .rnd_i (step_q),
    .rk_o  (rk_next)
  );

  aes_fi_round u_round (
    .state_i (state_q),
    .rkey_i  (rk_next),
    .last_i  (step_q == LAST_STEP),
    .state_o (round_out)
  );

  always_comb begin
    pt_d    = accept ? pt_i  : pt_q;
    key_d   = accept ? key_i : key_q;
    state_d = state_q;
    rk_d    = rk_q;
    if (whiten) begin
      state_d = pt_q ^ key_q;
      rk_d    = key_q;
    end else if (busy_q) begin
      state_d = round_out;
      rk_d    = rk_next;
    end
  end

  // flip stage in front of the register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pt_q    <= '0;
      key_q   <= '0;
      state_q <= '0;
      rk_q    <= '0;
    end else begin
      pt_q    <= pt_d  ^ fi_pt_mask;
      key_q   <= key_d ^ fi_key_mask;
      state_q <= state_d;
      rk_q    <= rk_d  ^ fi_rk_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && (step_q == LAST_STEP);
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        if (step_q == LAST_STEP) busy_q <= 1'b0;
        else                     step_q <= step_q + 1'b1;
      end
    end
  end

  assign ct_o   = state_q;
  assign done_o = done_q;
endmodule

// File: rtl/aes_fi_core_chk.sv
module aes_fi_core_chk
  import aes_fi_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_q,
  input logic [STEP_W-1:0] step_q,
  input logic              done_o,
  input logic              fi_en_i,
  input logic              fi_fire,
  input logic              fi_fired_o,
  input logic [CNT_W-1:0]  fi_cnt,
  input logic [BLK_W-1:0]  fi_pt_mask,
  input logic [BLK_W-1:0]  fi_key_mask,
  input logic [BLK_W-1:0]  fi_rk_mask
);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_o);

  assert_busy_no_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> !(busy_q && step_q == '0));

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fi_cnt == $past(fi_cnt) + 1'b1);

  assert_single_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(fi_pt_mask) + $countones(fi_key_mask) + $countones(fi_rk_mask)) <= 1);

  assert_fire_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fi_fired_o |-> !fi_fire);

  assert_fire_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fi_fire |=> fi_fired_o);

  assert_fired_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fi_fired_o && fi_en_i) |=> fi_fired_o);

  assert_fired_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fi_en_i |=> !fi_fired_o);

  assert_no_flip_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fi_en_i |-> (fi_pt_mask == '0 && fi_key_mask == '0 && fi_rk_mask == '0));
endmodule

bind aes_fi_core aes_fi_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_q      (busy_q),
  .step_q      (step_q),
  .done_o      (done_o),
  .fi_en_i     (fi_en_i),
  .fi_fire     (fi_fire),
  .fi_fired_o  (fi_fired_o),
  .fi_cnt      (fi_cnt),
  .fi_pt_mask  (fi_pt_mask),
  .fi_key_mask (fi_key_mask),
  .fi_rk_mask  (fi_rk_mask)
);

// File: tb/aes_fi_core_tb_top.sv
`timescale 1ns/1ps
module aes_fi_core_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] pt_i = '0, key_i = '0;
  logic         fi_en_i = 1'b0;
  logic [1:0]   fi_tgt_i = 2'd3;
  logic [6:0]   fi_bit_i = '0;
  logic [31:0]  fi_trig_i = 32'hffff_ffff;
  logic [127:0] ct_o;
  logic         done_o, fi_fired_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] tb_cnt;
  logic [7:0]  tb_sbox [256];

  always #5 clk_i = ~clk_i;

  aes_fi_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pt_i(pt_i), .key_i(key_i),
    .fi_en_i(fi_en_i), .fi_tgt_i(fi_tgt_i), .fi_bit_i(fi_bit_i), .fi_trig_i(fi_trig_i),
    .ct_o(ct_o), .done_o(done_o), .fi_fired_o(fi_fired_o)
  );

  // independent mirror of the cycle counter defined in R4
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tb_cnt <= '0; else tb_cnt <= tb_cnt + 1;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    while (bb != 0) begin
      if (bb[0]) p ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    return tb_sbox[x];
  endfunction

  function automatic logic [127:0] ref_aes(input logic [127:0] pt, input logic [127:0] key);
    logic [31:0]  w [44];
    logic [31:0]  t;
    logic [7:0]   rc, s [16], u [16];
    logic [127:0] blk;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb(t[23:16]) ^ rc, sb(t[15:8]), sb(t[7:0]), sb(t[31:24])};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    blk = pt ^ {w[0], w[1], w[2], w[3]};
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = blk[127-8*i -: 8];
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 4; k++) u[4*c+k] = sb(s[4*((c+k)%4)+k]);
      if (r < 10)
        for (int c = 0; c < 4; c++) begin
          s[4*c]   = m_mul(u[4*c],2) ^ m_mul(u[4*c+1],3) ^ u[4*c+2] ^ u[4*c+3];
          s[4*c+1] = u[4*c] ^ m_mul(u[4*c+1],2) ^ m_mul(u[4*c+2],3) ^ u[4*c+3];
          s[4*c+2] = u[4*c] ^ u[4*c+1] ^ m_mul(u[4*c+2],2) ^ m_mul(u[4*c+3],3);
          s[4*c+3] = m_mul(u[4*c],3) ^ u[4*c+1] ^ u[4*c+2] ^ m_mul(u[4*c+3],2);
        end
      else
        for (int i = 0; i < 16; i++) s[i] = u[i];
      for (int i = 0; i < 16; i++) blk[127-8*i -: 8] = s[i];
      blk = blk ^ {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    end
    return blk;
  endfunction

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // called at a negedge; drives start there; optional second start at sample dup_at
  task automatic run_enc(input logic [127:0] pt, input logic [127:0] key, input int dup_at,
                         output logic [127:0] ct, output int n);
    bit got = 0;
    pt_i = pt; key_i = key; start_i = 1'b1;
    n = 0;
    while (!got && n < 40) begin
      @(negedge clk_i);
      n++;
      if (n == 1) start_i = 1'b0;
      if (dup_at != 0 && n == dup_at) begin
        start_i = 1'b1; pt_i = ~pt; key_i = ~key;
      end
      if (dup_at != 0 && n == dup_at + 1) start_i = 1'b0;
      if (done_o) got = 1;
    end
    ct = ct_o;
  endtask

  task automatic rearm(input logic [1:0] tgt, input logic [6:0] b);
    @(negedge clk_i); fi_en_i = 1'b0;
    @(negedge clk_i); fi_en_i = 1'b1; fi_tgt_i = tgt; fi_bit_i = b;
  endtask

  initial begin
    logic [127:0] pt, key, ct, exp, mask;
    int n;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] y = 0;
      logic [7:0] v;
      if (x != 0)
        for (int k = 1; k < 256; k++) if (m_mul(8'(x), 8'(k)) == 8'h01) y = 8'(k);
      for (int i = 0; i < 8; i++)
        v[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8];
      tb_sbox[x] = v ^ 8'h63;
    end
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk_i);
    chk(done_o == 0 && fi_fired_o == 0, "R2", "reset outputs", {126'd0, done_o, fi_fired_o}, 0);
    chk(ct_o == 0, "R2", "reset ct", ct_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 known answers
    pt = 128'h00112233445566778899aabbccddeeff; key = 128'h000102030405060708090a0b0c0d0e0f;
    run_enc(pt, key, 0, ct, n);
    chk(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1", "kat1", ct, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk(n == 12, "R2", "latency edges+1", 128'(n), 128'd12);
    @(negedge clk_i);
    chk(done_o == 0, "R2", "done one cycle", {127'd0, done_o}, 0);
    repeat (3) @(negedge clk_i);
    chk(ct_o == ct, "R2", "ct held", ct_o, ct);
    pt = 128'h3243f6a8885a308d313198a2e0370734; key = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    run_enc(pt, key, 0, ct, n);
    chk(ct == 128'h3925841d02dc09fbdc118597196a0b32, "R1", "kat2", ct, 128'h3925841d02dc09fbdc118597196a0b32);
    chk(ref_aes(pt, key) == ct, "R1", "model vs kat2", ref_aes(pt, key), ct);

    // R1 random vectors, faults off
    for (int i = 0; i < 16; i++) begin
      pt = rand128(); key = rand128();
      @(negedge clk_i);
      run_enc(pt, key, 0, ct, n);
      chk(ct == ref_aes(pt, key) && n == 12, "R1", "random vector", ct, ref_aes(pt, key));
    end

    // R3 start while busy
    pt = rand128(); key = rand128();
    @(negedge clk_i);
    run_enc(pt, key, 4, ct, n);
    chk(ct == ref_aes(pt, key) && n == 12, "R3", "busy start ignored", ct, ref_aes(pt, key));
    begin
      int extra = 0;
      for (int i = 0; i < 15; i++) begin @(negedge clk_i); if (done_o) extra++; end
      chk(extra == 0, "R3", "no extra done", 128'(extra), 0);
    end

    // R4 trigger timing
    rearm(2'd3, 7'd0);
    fi_trig_i = tb_cnt + 5;
    repeat (5) @(negedge clk_i);
    chk(fi_fired_o == 0, "R4", "not yet fired", {127'd0, fi_fired_o}, 0);
    @(negedge clk_i);
    chk(fi_fired_o == 1, "R4", "fired at match", {127'd0, fi_fired_o}, 1);

    // R5 / R6 directed and random plaintext and key flips
    for (int i = 0; i < 8; i++) begin
      logic [1:0] tg = (i % 2 == 0) ? 2'd0 : 2'd1;
      logic [6:0] b  = (i == 0) ? 7'd0 : (i == 1) ? 7'd127 : 7'($urandom_range(0, 127));
      pt = rand128(); key = rand128();
      mask = 128'd1 << b;
      rearm(tg, b);
      fi_trig_i = tb_cnt;
      run_enc(pt, key, 0, ct, n);
      exp = (tg == 2'd0) ? ref_aes(pt ^ mask, key) : ref_aes(pt, key ^ mask);
      chk(ct == exp, (tg == 2'd0) ? "R5" : "R6", "flip result", ct, exp);
      chk(fi_fired_o == 1, "R9", "flag after flip", {127'd0, fi_fired_o}, 1);
    end

    // R9 no second fire without rearm
    pt = rand128(); key = rand128();
    @(negedge clk_i);
    fi_tgt_i = 2'd0; fi_trig_i = tb_cnt;
    run_enc(pt, key, 0, ct, n);
    chk(ct == ref_aes(pt, key), "R9", "fires once per arming", ct, ref_aes(pt, key));
    @(negedge clk_i); fi_en_i = 1'b0;
    @(negedge clk_i);
    chk(fi_fired_o == 0, "R9", "flag cleared", {127'd0, fi_fired_o}, 0);

    // R7 round-key flip mid-run
    for (int i = 0; i < 3; i++) begin
      pt = rand128(); key = rand128();
      rearm(2'd2, 7'($urandom_range(0, 127)));
      fi_trig_i = tb_cnt + 3 + i;
      run_enc(pt, key, 0, ct, n);
      chk(ct != ref_aes(pt, key), "R7", "round key flip diverges", ct, ref_aes(pt, key));
    end

    // R8 no-target code
    pt = rand128(); key = rand128();
    rearm(2'd3, 7'd5);
    fi_trig_i = tb_cnt;
    run_enc(pt, key, 0, ct, n);
    chk(ct == ref_aes(pt, key), "R8", "no target ct", ct, ref_aes(pt, key));
    chk(fi_fired_o == 1, "R8", "no target flag", {127'd0, fi_fired_o}, 1);

    // R10 disabled hook
    pt = rand128(); key = rand128();
    @(negedge clk_i); fi_en_i = 1'b0; fi_tgt_i = 2'd1;
    @(negedge clk_i);
    fi_trig_i = tb_cnt;
    run_enc(pt, key, 0, ct, n);
    chk(ct == ref_aes(pt, key), "R10", "disabled ct", ct, ref_aes(pt, key));
    chk(fi_fired_o == 0, "R10", "disabled flag", {127'd0, fi_fired_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule